// File: doc/BRIEF.md
# Serializer PHY power sequencer

This controller brings the PLL and serializer of a TMDS transmit PHY up and back down. A start request samples the pixel clock frequency in hertz. The frequency selects a PLL input divider and an output divider code from a band table. The block then writes the PLL word with its enable bit set and waits for the lock flag. Once lock is present, it programs the serializer configuration, current-control and calibration registers. A frequency that falls in no band ends the request at once with an error and issues no writes. A lock that never arrives ends the request with an error after a timeout.

A stop request parks the serializer with only its two detection bits set, turns the PLL off, and waits for lock to drop. If lock is still present when the timeout expires, the stop ends with an error. The PHY is reached through a one-write-at-a-time master port with a valid/ready handshake. Completion is reported by one-cycle `done` or `error` pulses. The divider settings chosen by the last start remain visible on `pll_idf` and `pll_odf` until the next start.

States:
- `S_IDLE`: waits for a request.
- `S_PLL_ON`: writes the PLL word.
- `S_LOCK_WAIT`: waits for lock.
- `S_SRZ_CFG`, `S_SRZ_ICTL`, `S_SRZ_CAL`: write the three serializer registers.
- `S_PARK_CFG`: writes the park word.
- `S_PLL_OFF`: writes the PLL off.
- `S_UNLOCK_WAIT`: waits for lock to drop.

Transitions:
- From `S_IDLE`:
  - A start with an in-band frequency goes to `S_PLL_ON`.
  - A start with an out-of-band frequency stays in `S_IDLE` and pulses error.
  - A stop goes to `S_PARK_CFG`.
- Every write state advances to the next state when `wr_ready` is high: `S_PLL_ON` to `S_LOCK_WAIT`, `S_SRZ_CFG` to `S_SRZ_ICTL`, `S_SRZ_ICTL` to `S_SRZ_CAL`, `S_PARK_CFG` to `S_PLL_OFF`, and `S_PLL_OFF` to `S_UNLOCK_WAIT`.
- `S_SRZ_CAL` returns to `S_IDLE` with done once its write is accepted.
- `S_LOCK_WAIT` goes to `S_SRZ_CFG` on lock, or returns to `S_IDLE` with error on timeout.
- `S_UNLOCK_WAIT` returns to `S_IDLE` with done when lock is low, or with error on timeout.

Top module: `phy_pwr_seq`

## Requirements
- R1: A start selects the dividers by band, where each band includes its lower bound and excludes its upper bound:
  - below 20 MHz: input divider 1, output code 3
  - 20 MHz to 42.5 MHz: input divider 2, output code 3
  - 42.5 MHz to 85 MHz: input divider 4, output code 2
  - 85 MHz to 170 MHz: input divider 8, output code 1
  - 170 MHz to 340 MHz: input divider 16, output code 0

  The chosen values appear on `pll_idf` and `pll_odf` from the cycle after the start is accepted.
- R2: A start whose frequency is at or above 340 MHz ends with an error pulse. It issues no register write, and `pll_idf` and `pll_odf` read 0.
- R3: The first write of an in-band start goes to address 0x510. Its data is {8'(output code), 8'(input divider), 8'd40, 8'h01}: the output code in bits 31:24, the input divider in bits 23:16, the feedback divider 40 in bits 15:8, and enable in bit 0.
- R4: After the PLL write, the block proceeds as soon as `pll_locked` is high. If lock has not come after LOCK_MS*CLK_HZ/1000 cycles, the start ends with an error and no further writes.
- R5: On lock, the configuration written to 0x504 is 32'h000D0001: bit 0 enable, bit 16 external data, bit 18 sink detection, bit 19 bias detection. Bit 24 (source termination) is added when the frequency is above 165 MHz.
- R6: Above 250 MHz and up to 300 MHz inclusive, 0x1110 is ORed into the configuration word, after bits 0, 1, 16 to 19 and 24 are masked out of it. The start then writes 0 to 0x518 and 0 to 0x520, in that order, and ends with done.
- R7: A stop writes 32'h000C0000 to 0x504 and then 0 to 0x510. It ends with done once `pll_locked` is low, or with an error if lock is still high after the timeout.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold. Each accepted write is issued once.
- R9: Start and stop requests that arrive while `busy` is high are ignored. When both arrive together in idle, start wins.
- R10: `done` and `error` are one-cycle pulses and never high together. `busy` is high from the cycle after an in-band start is accepted until the sequence ends, and `wr_valid` is low whenever `busy` is low.
- R11: `pll_idf` and `pll_odf` keep their values through a stop and change only on the next start.
- R12: After reset the block is idle: no write, no pulse, and zero divider outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Power-up request, sampled in idle |
| stop_req | input | 1 | Power-down request, sampled in idle |
| pix_freq_hz | input | 32 | Pixel (TMDS) clock frequency in Hz, sampled with start |
| pll_locked | input | 1 | PLL lock flag from the PHY |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 32 | Register write data |
| wr_ready | input | 1 | Write accepted when high with wr_valid |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse: sequence completed |
| error | output | 1 | One-cycle pulse: sequence failed |
| pll_idf | output | 8 | Input divider chosen by the last start |
| pll_odf | output | 2 | Output divider code chosen by the last start |

## Verification
The assertions take for granted that `wr_ready` is a free input that may stall any write for any number of cycles. They also assume that `pll_locked` is a level the PHY may raise or drop between writes, and that requests are only meaningful in idle. The stimulus drives a PLL model that raises lock a few cycles after an enabling write and drops it one cycle after a disabling write. The model can be forced never to lock or never to unlock, which reaches both timeout paths. The stimulus also alternates between an always-ready port and a port that stalls two cycles out of three, and sweeps the frequency in 5 MHz steps and at every band and table edge.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int NUM_BANDS = 5;
    localparam logic [31:0] BAND_TOP [NUM_BANDS] =
        '{32'd20_000_000, 32'd42_500_000, 32'd85_000_000, 32'd170_000_000, 32'd340_000_000};
    localparam logic [7:0]  BAND_IDF [NUM_BANDS] = '{8'd1, 8'd2, 8'd4, 8'd8, 8'd16};
    localparam logic [1:0]  BAND_ODF [NUM_BANDS] = '{2'd3, 2'd3, 2'd2, 2'd1, 2'd0};
    localparam logic [7:0]  FB_DIV = 8'd40;

    localparam logic [15:0] REG_SRZ_CFG = 16'h0504;
    localparam logic [15:0] REG_PLL     = 16'h0510;
    localparam logic [15:0] REG_ICTL    = 16'h0518;
    localparam logic [15:0] REG_CAL     = 16'h0520;

    localparam logic [31:0] CFG_RUN_BASE = 32'h000D_0001;
    localparam logic [31:0] CFG_SRC_TERM = 32'h0100_0000;
    localparam logic [31:0] CFG_OWN_MASK = 32'h010F_0003;
    localparam logic [31:0] CFG_PARK     = 32'h000C_0000;
    localparam logic [31:0] SRC_TERM_HZ  = 32'd165_000_000;

    // PHY tuning rows, both bounds inclusive, first match wins
    localparam int NUM_ROWS = 2;
    localparam logic [31:0] ROW_LO [NUM_ROWS] = '{32'd0, 32'd250_000_000};
    localparam logic [31:0] ROW_HI [NUM_ROWS] = '{32'd250_000_000, 32'd300_000_000};
    localparam logic [31:0] ROW_W0 [NUM_ROWS] = '{32'h0, 32'h0000_1110};
    localparam logic [31:0] ROW_W1 [NUM_ROWS] = '{32'h0, 32'h0};
    localparam logic [31:0] ROW_W2 [NUM_ROWS] = '{32'h0, 32'h0};

    typedef enum logic [3:0] {
        S_IDLE, S_PLL_ON, S_LOCK_WAIT, S_SRZ_CFG, S_SRZ_ICTL, S_SRZ_CAL,
        S_PARK_CFG, S_PLL_OFF, S_UNLOCK_WAIT
    } seq_state_e;

endpackage

// File: rtl/pll_band_sel.sv
module pll_band_sel
    import phy_seq_pkg::*;
(
    input  logic [31:0] freq_hz,
    output logic        hit,
    output logic [7:0]  idf,
    output logic [1:0]  odf
);
    // Bands are contiguous from zero; scanning downward leaves the lowest match.
    always_comb begin
        hit = 1'b0;
        idf = '0;
        odf = '0;
        for (int i = NUM_BANDS - 1; i >= 0; i--) begin
            if (freq_hz < BAND_TOP[i]) begin
                hit = 1'b1;
                idf = BAND_IDF[i];
                odf = BAND_ODF[i];
            end
        end
    end
endmodule

// File: rtl/srz_cfg_gen.sv
module srz_cfg_gen
    import phy_seq_pkg::*;
(
    input  logic [31:0] tmds_hz,
    output logic [31:0] cfg_word,
    output logic [31:0] ictl_word,
    output logic [31:0] cal_word
);
    logic [31:0] base, w0;

    always_comb begin
        base      = CFG_RUN_BASE | ((tmds_hz > SRC_TERM_HZ) ? CFG_SRC_TERM : 32'h0);
        w0        = '0;
        ictl_word = '0;
        cal_word  = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (tmds_hz >= ROW_LO[i] && tmds_hz <= ROW_HI[i]) begin
                w0        = ROW_W0[i];
                ictl_word = ROW_W1[i];
                cal_word  = ROW_W2[i];
            end
        end
        cfg_word = base | (w0 & ~CFG_OWN_MASK);
    end
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
    parameter int unsigned LIMIT = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned LOCK_MS = 50,
    parameter int          ADDR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic [31:0]       pix_freq_hz,
    input  logic              pll_locked,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [7:0]        pll_idf,
    output logic [1:0]        pll_odf
);
    localparam int unsigned WAIT_CYC = (CLK_HZ / 1000) * LOCK_MS;

    seq_state_e  st, nxt;
    logic        fin_ok, fin_err, capture, tmo;
    logic        band_hit;
    logic [7:0]  band_idf;
    logic [1:0]  band_odf;
    logic [31:0] freq_q, cfg_word, ictl_word, cal_word;

    pll_band_sel u_band (
        .freq_hz (pix_freq_hz),
        .hit     (band_hit),
        .idf     (band_idf),
        .odf     (band_odf)
    );

    srz_cfg_gen u_cfg (
        .tmds_hz   (freq_q),
        .cfg_word  (cfg_word),
        .ictl_word (ictl_word),
        .cal_word  (cal_word)
    );

    lock_timer #(.LIMIT(WAIT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st == S_LOCK_WAIT || st == S_UNLOCK_WAIT),
        .expired (tmo)
    );

    // Next state and completion decision
    always_comb begin
        nxt     = st;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        capture = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (start_req) begin
                    capture = 1'b1;
                    if (band_hit) nxt = S_PLL_ON;
                    else          fin_err = 1'b1;
                end else if (stop_req) begin
                    nxt = S_PARK_CFG;
                end
            end
            S_PLL_ON:    if (wr_ready) nxt = S_LOCK_WAIT;
            S_LOCK_WAIT: begin
                if (pll_locked) nxt = S_SRZ_CFG;
                else if (tmo) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end
            end
            S_SRZ_CFG:   if (wr_ready) nxt = S_SRZ_ICTL;
            S_SRZ_ICTL:  if (wr_ready) nxt = S_SRZ_CAL;
            S_SRZ_CAL: begin
                if (wr_ready) begin
                    nxt    = S_IDLE;
                    fin_ok = 1'b1;
                end
            end
            S_PARK_CFG:  if (wr_ready) nxt = S_PLL_OFF;
            S_PLL_OFF:   if (wr_ready) nxt = S_UNLOCK_WAIT;
            S_UNLOCK_WAIT: begin
                if (!pll_locked) begin
                    nxt    = S_IDLE;
                    fin_ok = 1'b1;
                end else if (tmo) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register and captured request data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            freq_q  <= '0;
            pll_idf <= '0;
            pll_odf <= '0;
        end else begin
            st <= nxt;
            if (capture) begin
                freq_q  <= pix_freq_hz;
                pll_idf <= band_idf;
                pll_odf <= band_odf;
            end
        end
    end

    // Completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done  <= fin_ok;
            error <= fin_err;
        end
    end

    // Write port driven from the state
    always_comb begin
        wr_valid = 1'b1;
        wr_addr  = '0;
        wr_data  = '0;
        unique case (st)
            S_PLL_ON: begin
                wr_addr = ADDR_W'(REG_PLL);
                wr_data = {6'd0, pll_odf, pll_idf, FB_DIV, 8'h01};
            end
            S_SRZ_CFG: begin
                wr_addr = ADDR_W'(REG_SRZ_CFG);
                wr_data = cfg_word;
            end
            S_SRZ_ICTL: begin
                wr_addr = ADDR_W'(REG_ICTL);
                wr_data = ictl_word;
            end
            S_SRZ_CAL: begin
                wr_addr = ADDR_W'(REG_CAL);
                wr_data = cal_word;
            end
            S_PARK_CFG: begin
                wr_addr = ADDR_W'(REG_SRZ_CFG);
                wr_data = CFG_PARK;
            end
            S_PLL_OFF: begin
                wr_addr = ADDR_W'(REG_PLL);
                wr_data = 32'h0;
            end
            default: wr_valid = 1'b0;
        endcase
    end

    assign busy = (st != S_IDLE);

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk
    import phy_seq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    p_pll_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(REG_PLL)) |->
            (wr_data == 32'h0 || (wr_data[0] && wr_data[15:8] == FB_DIV)));

    p_detect_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(REG_SRZ_CFG)) |-> (wr_data[19:18] == 2'b11));

    p_term_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(REG_SRZ_CFG) && wr_data[24]) |-> wr_data[0]);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(done && error));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !wr_valid);

endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;

    localparam int unsigned T_CLK_HZ = 20_000;
    localparam int unsigned T_MS     = 50;
    localparam int unsigned T_WAIT   = (T_CLK_HZ / 1000) * T_MS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, stop_req = 1'b0;
    logic [31:0] pix_freq_hz = '0;
    logic        pll_locked;
    logic        wr_valid, wr_ready = 1'b1;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        busy, done, error;
    logic [7:0]  pll_idf;
    logic [1:0]  pll_odf;

    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;   // 50 MHz

    phy_pwr_seq #(.CLK_HZ(T_CLK_HZ), .LOCK_MS(T_MS), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .pix_freq_hz(pix_freq_hz), .pll_locked(pll_locked),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .busy(busy), .done(done), .error(error), .pll_idf(pll_idf), .pll_odf(pll_odf)
    );

    // PLL model
    logic pll_on = 1'b0, pll_dead = 1'b0, pll_stuck = 1'b0;
    int   lk_cnt = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            pll_on <= 1'b0; lk_cnt <= 0; pll_locked <= 1'b0;
        end else begin
            if (wr_valid && wr_ready && wr_addr == 12'h510) begin
                if (wr_data[0]) pll_on <= 1'b1;
                else if (!pll_stuck) pll_on <= 1'b0;
            end
            lk_cnt     <= pll_on ? ((lk_cnt < 6) ? lk_cnt + 1 : lk_cnt) : 0;
            pll_locked <= pll_on && !pll_dead && (lk_cnt >= 4);
        end
    end

    // Stall pattern for the write port
    logic stall_mode = 1'b0;
    int   rdy_ctr = 0;
    always @(negedge clk) begin
        rdy_ctr  <= rdy_ctr + 1;
        wr_ready <= stall_mode ? (rdy_ctr % 3 == 2) : 1'b1;
    end

    // Write log and hold monitor
    logic [11:0] log_a [0:15];
    logic [31:0] log_d [0:15];
    int   log_n = 0, hold_bad = 0;
    logic prev_stall = 1'b0;
    logic [11:0] prev_a;
    logic [31:0] prev_d;
    always @(posedge clk) begin
        if (rst_n) begin
            if (prev_stall && (!wr_valid || wr_addr != prev_a || wr_data != prev_d)) hold_bad++;
            if (wr_valid && wr_ready) begin
                if (log_n < 16) begin log_a[log_n] = wr_addr; log_d[log_n] = wr_data; end
                log_n++;
            end
            prev_stall = wr_valid && !wr_ready;
            prev_a     = wr_addr;
            prev_d     = wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] e_idf(input logic [31:0] f);
        if (f < 32'd20_000_000)       return 8'd1;
        else if (f < 32'd42_500_000)  return 8'd2;
        else if (f < 32'd85_000_000)  return 8'd4;
        else if (f < 32'd170_000_000) return 8'd8;
        else if (f < 32'd340_000_000) return 8'd16;
        return 8'd0;
    endfunction

    function automatic logic [1:0] e_odf(input logic [31:0] f);
        logic [7:0] d;
        d = e_idf(f);
        if (d == 0) return 2'd0;
        if (d <= 2) return 2'd3;
        return 2'(4 - $clog2(d));
    endfunction

    function automatic logic [31:0] e_cfg(input logic [31:0] f);
        logic [31:0] v;
        v = 32'h000D_0001;
        if (f > 32'd165_000_000) v = v | (32'h1 << 24);
        if (f > 32'd250_000_000 && f <= 32'd300_000_000) v = v | 32'h1110;
        return v;
    endfunction

    bit got_done, got_err;
    int lat;

    task automatic wait_end();
        got_done = 0; got_err = 0; lat = 0;
        while (!(done || error) && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
        got_done = done;
        got_err  = error;
        @(negedge clk);
        chk(!done && !error, "R10 pulse width one cycle", {30'd0, done, error}, 32'd0);
    endtask

    task automatic issue(input logic [31:0] f, input bit with_stop);
        @(negedge clk);
        log_n = 0;
        start_req = 1'b1; stop_req = with_stop; pix_freq_hz = f;
        @(negedge clk);
        start_req = 1'b0; stop_req = 1'b0;
    endtask

    task automatic check_start(input logic [31:0] f);
        logic [7:0] xi;
        logic [1:0] xo;
        xi = e_idf(f);
        xo = e_odf(f);
        chk(pll_idf == xi, "R1 input divider", {24'd0, pll_idf}, {24'd0, xi});
        chk(pll_odf == xo, "R1 output code", {30'd0, pll_odf}, {30'd0, xo});
        if (xi == 0) begin
            chk(got_err && !got_done, "R2 out-of-band error", {30'd0, got_done, got_err}, 32'd1);
            chk(log_n == 0, "R2 no writes", log_n, 0);
        end else begin
            chk(got_done && !got_err, "R6 start done", {30'd0, got_done, got_err}, 32'd2);
            chk(log_n == 4, "R8 write count", log_n, 4);
            chk(log_a[0] == 12'h510 && log_d[0] == {6'd0, xo, xi, 8'd40, 8'h01},
                "R3 PLL word", log_d[0], {6'd0, xo, xi, 8'd40, 8'h01});
            chk(log_a[1] == 12'h504 && log_d[1] == e_cfg(f), "R5 R6 serializer config", log_d[1], e_cfg(f));
            chk(log_a[2] == 12'h518 && log_d[2] == 0, "R6 current control", {log_a[2], log_d[2][19:0]}, 32'h5180_0000);
            chk(log_a[3] == 12'h520 && log_d[3] == 0, "R6 calibration", {log_a[3], log_d[3][19:0]}, 32'h5200_0000);
        end
    endtask

    task automatic do_stop(input bit expect_ok);
        logic [7:0] hi;
        logic [1:0] ho;
        hi = pll_idf; ho = pll_odf;
        @(negedge clk);
        log_n = 0;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(busy, "R10 busy during stop", {31'd0, busy}, 1);
        wait_end();
        chk(log_n == 2 && log_a[0] == 12'h504 && log_d[0] == 32'h000C_0000,
            "R7 park config", log_d[0], 32'h000C_0000);
        chk(log_a[1] == 12'h510 && log_d[1] == 0, "R7 PLL off", log_d[1], 0);
        if (expect_ok) chk(got_done && !got_err, "R7 stop done", {30'd0, got_done, got_err}, 2);
        else           chk(got_err && !got_done, "R7 stop lock stuck error", {30'd0, got_done, got_err}, 1);
        chk(pll_idf == hi && pll_odf == ho, "R11 dividers held", {22'd0, pll_odf, pll_idf}, {22'd0, ho, hi});
    endtask

    task automatic full(input logic [31:0] f);
        issue(f, 1'b0);
        chk(busy == (e_idf(f) != 0), "R10 busy after start", {31'd0, busy}, {31'd0, e_idf(f) != 0});
        wait_end();
        check_start(f);
        if (e_idf(f) != 0) do_stop(1'b1);
    endtask

    bit finished = 0;

    initial begin : watchdog
        for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] edges [20];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !wr_valid && !done && !error, "R12 idle after reset",
            {28'd0, busy, wr_valid, done, error}, 0);
        chk(pll_idf == 0 && pll_odf == 0, "R12 divider outputs zero", {22'd0, pll_odf, pll_idf}, 0);

        // Boundary points
        edges = '{32'd0, 32'd19_999_999, 32'd20_000_000, 32'd42_499_999, 32'd42_500_000,
                  32'd84_999_999, 32'd85_000_000, 32'd165_000_000, 32'd165_000_001,
                  32'd169_999_999, 32'd170_000_000, 32'd250_000_000, 32'd250_000_001,
                  32'd300_000_000, 32'd300_000_001, 32'd339_999_999, 32'd340_000_000,
                  32'd340_000_001, 32'd400_000_000, 32'hFFFF_FFFF};
        foreach (edges[i]) full(edges[i]);

        // Sweep in 5 MHz steps, alternate stalling write port
        for (int k = 0; k <= 80; k++) begin
            stall_mode = k[0];
            full(32'(k) * 32'd5_000_000);
        end
        stall_mode = 1'b0;

        // R9: simultaneous start and stop in idle, start wins
        issue(32'd100_000_000, 1'b1);
        wait_end();
        chk(got_done && log_n == 4 && log_a[0] == 12'h510, "R9 start wins over stop", log_n, 4);
        do_stop(1'b1);

        // R9: requests while busy are ignored
        issue(32'd60_000_000, 1'b0);
        start_req = 1'b1; stop_req = 1'b1; pix_freq_hz = 32'd300_000_000;
        @(negedge clk);
        start_req = 1'b0; stop_req = 1'b0;
        wait_end();
        check_start(32'd60_000_000);
        chk(log_n == 4, "R9 busy requests ignored", log_n, 4);
        do_stop(1'b1);

        // R4: lock never arrives
        pll_dead = 1'b1;
        issue(32'd148_500_000, 1'b0);
        wait_end();
        chk(got_err && !got_done, "R4 lock timeout error", {30'd0, got_done, got_err}, 1);
        chk(log_n == 1, "R4 no writes after timeout", log_n, 1);
        chk(lat >= int'(T_WAIT) && lat <= int'(T_WAIT) + 3, "R4 timeout length", lat, T_WAIT);
        pll_dead = 1'b0;
        repeat (10) @(negedge clk);

        // R4: lock present proceeds, then R7 stop with lock stuck
        full(32'd74_250_000);
        issue(32'd74_250_000, 1'b0);
        wait_end();
        check_start(32'd74_250_000);
        pll_stuck = 1'b1;
        do_stop(1'b0);
        chk(lat >= int'(T_WAIT) && lat <= int'(T_WAIT) + 4, "R7 unlock timeout length", lat, T_WAIT);
        pll_stuck = 1'b0;

        // R8 hold monitor
        chk(hold_bad == 0, "R8 stalled write held", hold_bad, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule